// File: doc/BRIEF.md
# Two-Threshold Link Backpressure Controller

This block throttles a point-to-point flit link using a hysteresis pair of thresholds rather than a credit per flit. On the receiving side it keeps a count of empty slots in the input buffer. Each arrival strobe takes one slot and each departure strobe returns one. When the count falls under a low-water mark, a single-bit stop level is raised. The level is lowered only after the count climbs past a higher high-water mark. The level travels to the sending side through a chain of registers whose length is a parameter. There, a send-enable register changes state only when the level arriving at its end disagrees with it. The wire therefore changes value once per threshold crossing, not once per flit.

The two marks are sized against the loop delay. The low mark must leave room for every flit that can still be launched before the stop reaches the sender. The high mark must leave enough queued flits to keep the drain busy while the restart travels back. A package predicate applies both rules, and the top refuses to elaborate when the parameters break either of them.

Top module: `onoff_backpressure`

## Requirements
- R1: After reset the free-slot count equals DEPTH, the stop level is 0 and send-enable is 1.
- R2: On a clock edge where only the arrival strobe is high and slots remain, the free count drops by one. Where only the departure strobe is high and the count is below DEPTH, it rises by one. Both strobes high together, or neither, leave it unchanged.
- R3: An arrival alone at a free count of 0 leaves the count at 0. A departure alone at a free count of DEPTH leaves it at DEPTH. The count never exceeds DEPTH.
- R4: While the stop level is 0, a free count below OFF_THR raises the stop level (1 = stop) on the next edge.
- R5: While the stop level is 1, a free count above ON_THR lowers it on the next edge. Between the two marks the level holds. A full fill followed by a full drain produces exactly one rise and one fall.
- R6: Send-enable equals the inverse of the stop level from SIG_DELAY+1 edges earlier, and it changes only when the delayed level disagrees with it.
- R7: With a sender that launches one flit per enabled cycle over a FLIT_DELAY-cycle link, no arrival ever meets a full buffer. Once traffic has started, the drain never finds the buffer empty.
- R8: The configuration predicate accepts a set of parameters only when all of the following hold: ON_THR > OFF_THR; OFF_THR >= SIG_DELAY+FLIT_DELAY+3; ON_THR <= DEPTH-SIG_DELAY-FLIT_DELAY-4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arrive_i | input | 1 | A flit was written into the receive buffer this cycle |
| depart_i | input | 1 | A flit left the receive buffer this cycle |
| free_slots_o | output | $clog2(DEPTH+1) | Current count of empty buffer slots |
| link_off_o | output | 1 | Stop level driven onto the signaling wire at the receiver end |
| send_en_o | output | 1 | Sender may launch a flit this cycle |

## Verification
The bench uses the default build: DEPTH=16, OFF_THR=6, ON_THR=9, SIG_DELAY=2, FLIT_DELAY=1. With only 17 count values, it can walk the counter through every level, including both saturation points. It can also wiggle the count by one at every level, so each threshold is approached from both directions. In this build both marks sit exactly on their sizing limits. The closed-loop phases (a stall, then full-rate and partial-rate draining) therefore test the overflow margin and the starvation margin with no slack. The predicate is also probed with configurations that break each rule by one.

// File: rtl/onoff_pkg.sv
package onoff_pkg;

    typedef enum logic {
        LINK_ON  = 1'b0,
        LINK_OFF = 1'b1
    } link_state_e;

    typedef struct packed {
        logic arrive;
        logic depart;
    } slot_evt_t;

    // Free slots that must remain at the stop point to absorb flits still in flight.
    function automatic int min_off_mark(input int sig_delay, input int flit_delay);
        return sig_delay + flit_delay + 3;
    endfunction

    // Highest restart mark that still leaves enough queued flits to cover the restart latency.
    function automatic int max_on_mark(input int depth, input int sig_delay, input int flit_delay);
        return depth - sig_delay - flit_delay - 4;
    endfunction

    function automatic bit thresholds_ok(input int depth, input int off_thr, input int on_thr,
                                         input int sig_delay, input int flit_delay);
        return (on_thr > off_thr) && (off_thr > 0) && (on_thr < depth) &&
               (sig_delay >= 1) && (flit_delay >= 0) &&
               (off_thr >= min_off_mark(sig_delay, flit_delay)) &&
               (on_thr <= max_on_mark(depth, sig_delay, flit_delay));
    endfunction

endpackage

// File: rtl/onoff_slot_tracker.sv
module onoff_slot_tracker
    import onoff_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  slot_evt_t     evt,
    output logic [CW-1:0] free_o
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    logic [CW-1:0] free_q;
    logic [CW-1:0] free_d;
    logic          take;
    logic          give;

    always_comb begin
        take   = evt.arrive && !evt.depart && (free_q != '0);
        give   = evt.depart && !evt.arrive && (free_q != FULL_C);
        free_d = free_q;
        if (take)
            free_d = free_q - 1'b1;
        else if (give)
            free_d = free_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            free_q <= FULL_C;
        else
            free_q <= free_d;
    end

    assign free_o = free_q;
endmodule

// File: rtl/onoff_hysteresis.sv
module onoff_hysteresis
    import onoff_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int OFF_THR = 6,
    parameter int ON_THR  = 9,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] free_i,
    output link_state_e   state_o
);
    localparam logic [CW-1:0] OFF_C = CW'(OFF_THR);
    localparam logic [CW-1:0] ON_C  = CW'(ON_THR);

    link_state_e state_q;
    link_state_e state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            LINK_ON:  if (free_i < OFF_C) state_d = LINK_OFF;
            LINK_OFF: if (free_i > ON_C)  state_d = LINK_ON;
            default:  state_d = LINK_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= LINK_ON;
        else
            state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/onoff_sig_pipe.sv
module onoff_sig_pipe #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES == 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q <= 1'b0;
                else
                    stage_q <= d_i;
            end
            assign q_o = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] sr_q;
            always_ff @(posedge clk) begin
                if (rst)
                    sr_q <= '0;
                else
                    sr_q <= {sr_q[STAGES-2:0], d_i};
            end
            assign q_o = sr_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/onoff_sender.sv
module onoff_sender (
    input  logic clk,
    input  logic rst,
    input  logic far_off_i,
    output logic send_en_o
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b1;
        else if (far_off_i && en_q)
            en_q <= 1'b0;
        else if (!far_off_i && !en_q)
            en_q <= 1'b1;
    end

    assign send_en_o = en_q;
endmodule

// File: rtl/onoff_backpressure.sv
module onoff_backpressure
    import onoff_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int OFF_THR    = 6,
    parameter int ON_THR     = 9,
    parameter int SIG_DELAY  = 2,
    parameter int FLIT_DELAY = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         arrive_i,
    input  logic                         depart_i,
    output logic [$clog2(DEPTH+1)-1:0]   free_slots_o,
    output logic                         link_off_o,
    output logic                         send_en_o
);
    localparam int CW = $clog2(DEPTH + 1);

    // R8: reject threshold pairs that could overflow or starve the buffer
    generate
        if (!thresholds_ok(DEPTH, OFF_THR, ON_THR, SIG_DELAY, FLIT_DELAY)) begin : g_bad_cfg
            $error("onoff_backpressure: thresholds violate the loop-delay sizing rules");
        end
    endgenerate

    slot_evt_t     evt;
    logic [CW-1:0] free_cnt;
    link_state_e   rx_state;
    logic          near_off;
    logic          far_off;

    assign evt.arrive = arrive_i;
    assign evt.depart = depart_i;

    onoff_slot_tracker #(.DEPTH(DEPTH)) u_track (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .free_o (free_cnt)
    );

    onoff_hysteresis #(.DEPTH(DEPTH), .OFF_THR(OFF_THR), .ON_THR(ON_THR)) u_hyst (
        .clk     (clk),
        .rst     (rst),
        .free_i  (free_cnt),
        .state_o (rx_state)
    );

    assign near_off = (rx_state == LINK_OFF);

    onoff_sig_pipe #(.STAGES(SIG_DELAY)) u_wire (
        .clk (clk),
        .rst (rst),
        .d_i (near_off),
        .q_o (far_off)
    );

    onoff_sender u_send (
        .clk       (clk),
        .rst       (rst),
        .far_off_i (far_off),
        .send_en_o (send_en_o)
    );

    assign free_slots_o = free_cnt;
    assign link_off_o   = near_off;
endmodule

// File: rtl/onoff_checker.sv
module onoff_checker #(
    parameter int DEPTH   = 16,
    parameter int OFF_THR = 6,
    parameter int ON_THR  = 9,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          arrive_i,
    input logic          depart_i,
    input logic [CW-1:0] free_slots_o,
    input logic          link_off_o,
    input logic          send_en_o,
    input logic          far_off
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] OFF_C  = CW'(OFF_THR);
    localparam logic [CW-1:0] ON_C   = CW'(ON_THR);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    assert_free_range_R3: assert property (@(posedge clk) disable iff (rst)
        free_slots_o <= FULL_C);

    assert_full_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (arrive_i && !depart_i && free_slots_o == '0) |=> (free_slots_o == '0));

    assert_take_step_R2: assert property (@(posedge clk) disable iff (rst)
        (arrive_i && !depart_i && free_slots_o != '0) |=> (free_slots_o + ONE_C == $past(free_slots_o)));

    assert_both_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (arrive_i && depart_i) |=> $stable(free_slots_o));

    assert_off_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (!link_off_o && free_slots_o < OFF_C) |=> link_off_o);

    assert_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (link_off_o && free_slots_o > ON_C) |=> !link_off_o);

    assert_band_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (free_slots_o >= OFF_C && free_slots_o <= ON_C) |=> $stable(link_off_o));

    assert_en_flip_R6: assert property (@(posedge clk) disable iff (rst)
        (far_off == send_en_o) |=> (send_en_o != $past(send_en_o)));

    assert_en_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (far_off != send_en_o) |=> $stable(send_en_o));
endmodule

bind onoff_backpressure onoff_checker #(
    .DEPTH   (DEPTH),
    .OFF_THR (OFF_THR),
    .ON_THR  (ON_THR)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .arrive_i     (arrive_i),
    .depart_i     (depart_i),
    .free_slots_o (free_slots_o),
    .link_off_o   (link_off_o),
    .send_en_o    (send_en_o),
    .far_off      (far_off)
);

// File: tb/sim_onoff_backpressure.sv
`timescale 1ns/1ps
module sim_onoff_backpressure;
    localparam int DEPTH = 16;
    localparam int OFFT  = 6;
    localparam int ONT   = 9;
    localparam int SD    = 2;
    localparam int FD    = 1;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arrive = 1'b0;
    logic          depart = 1'b0;
    logic [CW-1:0] free_slots;
    logic          link_off;
    logic          send_en;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    int  mfree  = DEPTH;
    bit  moff   = 1'b0;
    bit  hist [0:15];
    int  toggles = 0;
    bit  inflight = 1'b0;

    always #2.5 clk = ~clk;

    onoff_backpressure #(.DEPTH(DEPTH), .OFF_THR(OFFT), .ON_THR(ONT),
                         .SIG_DELAY(SD), .FLIT_DELAY(FD)) u0 (
        .clk          (clk),
        .rst          (rst),
        .arrive_i     (arrive),
        .depart_i     (depart),
        .free_slots_o (free_slots),
        .link_off_o   (link_off),
        .send_en_o    (send_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge: drive, let one rising edge pass, then compare.
    task automatic step(input bit a, input bit d);
        bit nxt_off;
        arrive = a;
        depart = d;
        @(posedge clk);
        nxt_off = moff ? !(mfree > ONT) : (mfree < OFFT);
        if (a && !d && mfree > 0) mfree--;
        else if (d && !a && mfree < DEPTH) mfree++;
        if (nxt_off != moff) toggles++;
        moff = nxt_off;
        for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = moff;
        @(negedge clk);
        check(int'(free_slots) == mfree, "R2", "free count", int'(free_slots), mfree);
        check(link_off == moff, moff ? "R4" : "R5", "stop level", int'(link_off), int'(moff));
        check(send_en == !hist[SD+1], "R6", "send enable", int'(send_en), int'(!hist[SD+1]));
    endtask

    // Closed loop: the sender launches whenever enabled, the flit lands FD(=1) edges later.
    task automatic loop_step(input bit drain, input bit watch_starve);
        bit a;
        bit s;
        a = inflight;
        s = send_en;
        check(!(a && !drain && mfree == 0), "R7", "arrival into full buffer", mfree, 1);
        if (watch_starve)
            check(!(drain && !a && mfree == DEPTH), "R7", "drain found buffer empty", mfree, DEPTH - 1);
        step(a, drain);
        inflight = s;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) hist[i] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(int'(free_slots) == DEPTH, "R1", "reset free count", int'(free_slots), DEPTH);
        check(link_off == 1'b0, "R1", "reset stop level", int'(link_off), 0);
        check(send_en == 1'b1, "R1", "reset send enable", int'(send_en), 1);

        // Fill completely, then push past empty-slot zero
        toggles = 0;
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        check(int'(free_slots) == 0, "R3", "arrival at zero free ignored", int'(free_slots), 0);
        step(1'b1, 1'b0);
        check(int'(free_slots) == 0, "R3", "second arrival at zero free ignored", int'(free_slots), 0);
        step(1'b1, 1'b1);
        check(int'(free_slots) == 0, "R2", "simultaneous strobes keep count", int'(free_slots), 0);
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check(int'(free_slots) == DEPTH, "R3", "departure at full free ignored", int'(free_slots), DEPTH);
        for (int i = 0; i < SD + 3; i++) step(1'b0, 1'b0);
        check(toggles == 2, "R5", "one rise and one fall per fill-drain", toggles, 2);
        check(send_en == 1'b1, "R6", "sender re-enabled after drain", int'(send_en), 1);

        // Walk every level and wiggle by one in both directions
        for (int k = DEPTH; k >= 0; k--) begin
            while (mfree > k) step(1'b1, 1'b0);
            step(1'b0, 1'b1);
            step(1'b1, 1'b0);
            step(1'b1, 1'b0);
            step(1'b0, 1'b1);
            step(1'b1, 1'b1);
        end
        for (int k = 0; k <= DEPTH; k++) begin
            while (mfree < k) step(1'b0, 1'b1);
            step(1'b1, 1'b0);
            step(1'b0, 1'b1);
            step(1'b0, 1'b1);
            step(1'b1, 1'b0);
        end
        for (int i = 0; i < SD + 3; i++) step(1'b0, 1'b0);

        // Closed loop: half-rate drain
        inflight = 1'b0;
        for (int c = 0; c < 400; c++) loop_step(c % 2 == 0, c > 30);
        // Stall the drain, then resume at full rate
        for (int c = 0; c < 40; c++) loop_step(1'b0, 1'b0);
        check(mfree >= 0, "R7", "stall kept count non-negative", mfree, 0);
        for (int c = 0; c < 300; c++) loop_step(1'b1, 1'b1);
        // Two-of-three drain
        for (int c = 0; c < 300; c++) loop_step(c % 3 != 0, 1'b1);

        // R8 configuration predicate
        check(onoff_pkg::thresholds_ok(16, 6, 9, 2, 1) == 1'b1, "R8", "default config accepted", 0, 1);
        check(onoff_pkg::thresholds_ok(16, 9, 9, 2, 1) == 1'b0, "R8", "equal marks rejected", 1, 0);
        check(onoff_pkg::thresholds_ok(16, 5, 9, 2, 1) == 1'b0, "R8", "low mark too small rejected", 1, 0);
        check(onoff_pkg::thresholds_ok(16, 6, 10, 2, 1) == 1'b0, "R8", "high mark too large rejected", 1, 0);
        check(onoff_pkg::thresholds_ok(24, 8, 12, 3, 2) == 1'b1, "R8", "deeper config accepted", 0, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule